// File: doc/BRIEF.md
# Content-Deduplicating Block Write Remapper

This block sits in front of a small non-volatile block store and keeps duplicate block contents from being written twice. Every accepted block write is hashed with an 8-bit CRC. The hash selects one set of a small content index. A candidate entry only counts as a duplicate after the stored copy it points to has been compared in full against the incoming data. A confirmed duplicate cancels the store write. The logical address is pointed at the existing copy and that copy's reference count goes up. A block with no duplicate is placed in a free storage slot. When possible it uses the slot whose number equals its own logical address, and that placement is recorded with a single identity flag instead of a pointer.

When a logical address is overwritten, its old copy is released first. The write reaches that copy through the forward map, then through a per-slot back-pointer to its index entry, and decrements the entry's count. When the last reference goes, the entry is invalidated and the slot returns to the free bitmap. Three cases fall back to simpler placement:

- A saturated count makes the write allocate a redundant copy with a fresh index entry.
- A full index set stores the block unindexed.
- A full store reports an error.

Reads translate a logical address through the forward map and return the data, the storage slot and the identity flag.

Top module: `dedup_remap`

## Requirements
- R1: After reset, `done` and `busy` are low, `free_count` equals the number of storage slots (2**SADDR_W), and a read of any logical address returns data 0, slot 0 and identity 0.
- R2: The content hash is CRC-8 with polynomial 0x07, initial value 0, and data bits fed most significant first. Its low SET_W bits pick the index set, which holds WAYS entries.
- R3: A write whose data equals the stored copy behind a valid, non-saturated entry with the same hash completes with status 1 (duplicate). It consumes no slot and maps the logical address to that copy.
- R4: Overwriting a mapped logical address first drops one reference from its old copy. An unindexed copy, or an indexed one whose count reaches zero, is freed and its index entry invalidated, so `free_count` rises by one before the new data is placed.
- R5: A reference count never exceeds 2**CNT_W-1 (255 by default). A duplicate of a saturated copy is instead stored in a newly allocated slot under a new index entry with count 1, and later duplicates may match that new entry.
- R6: A unique block goes to slot number equal to its logical address when that address is below 2**SADDR_W and the slot is free; such a mapping reads back with identity 1. Otherwise it goes to the lowest-numbered free slot, with identity 0.
- R7: If the selected set has no free entry, a unique block is stored without an index entry and completes with status 2. Later writes of the same data never match it.
- R8: If no slot is free, the write completes with status 3 and no slot is allocated. The logical address is left unmapped and reads return 0.
- R9: A read request returns data, slot and identity flag with `rd_valid` on the cycle after `rd_req`.
- R10: A write request raised while `busy` is high is ignored and changes no mapping.
- R11: Each accepted write produces exactly one one-cycle `done` pulse, three cycles after acceptance, with `status` valid in that cycle. Status codes: 0 stored and indexed, 1 duplicate, 2 stored unindexed, 3 no space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request, accepted when not busy |
| wr_addr | input | LADDR_W | Logical block address of the write |
| wr_data | input | DATA_W | Block contents to write |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Write outcome code, valid with done |
| rd_req | input | 1 | Read request |
| rd_addr | input | LADDR_W | Logical block address to read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Block contents seen at the logical address |
| rd_loc | output | SADDR_W | Storage slot the address maps to |
| rd_ident | output | 1 | Mapping uses the identity flag |
| free_count | output | SADDR_W+1 | Number of free storage slots |

## Verification
A reference count that is one too high or too low does not show up at once. A count that is too high leaks a slot, so `free_count` stays low after the last release. A count that is too low frees a shared slot early, and a later unique write overwrites it. That corruption appears on the next read of any sharer, or as a status 3 that should have succeeded. Forward-map and identity-flag errors appear on the very next read as a wrong `rd_loc` or `rd_ident`. A broken content comparison turns an expected status 2 or 0 into 1, or the reverse, on the write that triggers it. The stimulus therefore follows each write with reads of every address that shares a slot, and it tracks `free_count` after every write.

// File: rtl/dedup_pkg.sv
package dedup_pkg;

  typedef enum logic [1:0] {
    WS_STORED    = 2'd0,
    WS_DUP       = 2'd1,
    WS_UNINDEXED = 2'd2,
    WS_NOSPACE   = 2'd3
  } wr_status_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RELEASE = 2'd1,
    PH_LOOKUP  = 2'd2
  } phase_e;

  // one bit of CRC-8, polynomial x^8+x^2+x+1, message bit fed MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
  endfunction

endpackage

// File: rtl/dedup_freemap.sv
module dedup_freemap #(
  parameter int SADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SADDR_W-1:0] pref_idx,
  input  logic               pref_ok,
  input  logic               alloc_en,
  input  logic [SADDR_W-1:0] alloc_idx,
  input  logic               rel_en,
  input  logic [SADDR_W-1:0] rel_idx,
  output logic               any_free,
  output logic [SADDR_W-1:0] pick_idx,
  output logic               pick_pref,
  output logic [SADDR_W:0]   free_cnt
);
  localparam int NS = 1 << SADDR_W;

  logic [NS-1:0] used_q;
  logic [SADDR_W-1:0] low_idx;

  always_comb begin
    low_idx  = '0;
    any_free = 1'b0;
    free_cnt = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        low_idx  = SADDR_W'(i);
        any_free = 1'b1;
        free_cnt = free_cnt + 1'b1;
      end
    end
    pick_pref = pref_ok && !used_q[pref_idx];
    pick_idx  = pick_pref ? pref_idx : low_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
    end else begin
      if (rel_en)   used_q[rel_idx]   <= 1'b0;
      if (alloc_en) used_q[alloc_idx] <= 1'b1;
    end
  end

  // R6
  alloc_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !used_q[alloc_idx]);
  // R4
  release_on_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> used_q[rel_idx]);

endmodule

// File: rtl/dedup_hashtab.sv
module dedup_hashtab #(
  parameter int SET_W   = 1,
  parameter int WAYS    = 2,
  parameter int CNT_W   = 8,
  parameter int SADDR_W = 3,
  localparam int NE     = (1 << SET_W) * WAYS,
  localparam int EIDX_W = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SET_W-1:0]                lk_set,
  input  logic [7:0]                      lk_hash,
  output logic [WAYS-1:0]                 cand,
  output logic [WAYS-1:0][SADDR_W-1:0]    cand_addr,
  output logic [WAYS-1:0]                 open_way,
  input  logic                            dec_en,
  input  logic [EIDX_W-1:0]               dec_idx,
  output logic                            dec_last,
  input  logic                            inc_en,
  input  logic [EIDX_W-1:0]               inc_idx,
  input  logic                            ins_en,
  input  logic [EIDX_W-1:0]               ins_idx,
  input  logic [7:0]                      ins_hash,
  input  logic [SADDR_W-1:0]              ins_addr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic               e_valid [NE];
  logic [7:0]         e_hash  [NE];
  logic [SADDR_W-1:0] e_addr  [NE];
  logic [CNT_W-1:0]   e_cnt   [NE];

  function automatic logic [EIDX_W-1:0] slot_of(input logic [SET_W-1:0] s, input int w);
    return EIDX_W'(int'(s) * WAYS + w);
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [EIDX_W-1:0] ix;
    assign ix           = slot_of(lk_set, w);
    assign cand[w]      = e_valid[ix] && (e_hash[ix] == lk_hash) && (e_cnt[ix] != CNT_MAX);
    assign cand_addr[w] = e_addr[ix];
    assign open_way[w]  = !e_valid[ix];
  end

  assign dec_last = (e_cnt[dec_idx] == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        e_valid[i] <= 1'b0;
        e_hash[i]  <= '0;
        e_addr[i]  <= '0;
        e_cnt[i]   <= '0;
      end
    end else begin
      if (dec_en) begin
        e_cnt[dec_idx] <= e_cnt[dec_idx] - 1'b1;
        if (dec_last) e_valid[dec_idx] <= 1'b0;
      end
      if (inc_en) e_cnt[inc_idx] <= e_cnt[inc_idx] + 1'b1;
      if (ins_en) begin
        e_valid[ins_idx] <= 1'b1;
        e_hash[ins_idx]  <= ins_hash;
        e_addr[ins_idx]  <= ins_addr;
        e_cnt[ins_idx]   <= CNT_W'(1);
      end
    end
  end

  // R5
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |-> (e_valid[inc_idx] && e_cnt[inc_idx] != CNT_MAX));
  // R4
  dec_live_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (e_valid[dec_idx] && e_cnt[dec_idx] != '0));
  // R7
  insert_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !e_valid[ins_idx]);

endmodule

// File: rtl/dedup_remap.sv
module dedup_remap
  import dedup_pkg::*;
#(
  parameter int LADDR_W = 4,
  parameter int SADDR_W = 3,
  parameter int DATA_W  = 32,
  parameter int SET_W   = 1,
  parameter int WAYS    = 2,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [LADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               busy,
  output logic               done,
  output logic [1:0]         status,
  input  logic               rd_req,
  input  logic [LADDR_W-1:0] rd_addr,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic [SADDR_W-1:0] rd_loc,
  output logic               rd_ident,
  output logic [SADDR_W:0]   free_count
);
  localparam int NL     = 1 << LADDR_W;
  localparam int NS     = 1 << SADDR_W;
  localparam int NE     = (1 << SET_W) * WAYS;
  localparam int EIDX_W = (NE > 1) ? $clog2(NE) : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [7:0] crc8_of(input logic [DATA_W-1:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = DATA_W - 1; i >= 0; i--) c = crc8_step(c, d[i]);
    return c;
  endfunction

  function automatic logic in_store(input logic [LADDR_W-1:0] a);
    return (a >> SADDR_W) == '0;
  endfunction

  phase_e             ph_q;
  logic [LADDR_W-1:0] q_addr;
  logic [DATA_W-1:0]  q_data;
  logic [7:0]         q_hash;

  logic [DATA_W-1:0]  store_q   [NS];
  logic               inv_val_q [NS];
  logic [EIDX_W-1:0]  inv_ptr_q [NS];
  logic               fwd_val_q [NL];
  logic               fwd_id_q  [NL];
  logic [SADDR_W-1:0] fwd_ptr_q [NL];

  // release path
  logic [SADDR_W-1:0] rel_loc;
  logic               rel_has, rel_indexed, dec_last;
  logic               ev_dec, ev_free;

  assign rel_loc     = fwd_id_q[q_addr] ? q_addr[SADDR_W-1:0] : fwd_ptr_q[q_addr];
  assign rel_has     = (ph_q == PH_RELEASE) && fwd_val_q[q_addr];
  assign rel_indexed = inv_val_q[rel_loc];
  assign ev_dec      = rel_has && rel_indexed;
  assign ev_free     = rel_has && (!rel_indexed || dec_last);

  // lookup path
  logic [SET_W-1:0]                set_sel;
  logic [WAYS-1:0]                 cand, open_way, way_match;
  logic [WAYS-1:0][SADDR_W-1:0]    cand_addr;
  logic                            any_hit, any_open;
  logic [WAY_W-1:0]                hit_w, open_w;
  logic [SADDR_W-1:0]              hit_addr;
  logic                            any_free, pick_pref;
  logic [SADDR_W-1:0]              pick_idx;
  logic                            ev_dup, ev_nospace, ev_alloc, ev_ins;
  logic [EIDX_W-1:0]               hit_ent, open_ent;

  assign set_sel = q_hash[SET_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = cand[w] && (store_q[cand_addr[w]] == q_data);
  end

  always_comb begin
    any_hit  = 1'b0;
    any_open = 1'b0;
    hit_w    = '0;
    open_w   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) begin any_hit = 1'b1;  hit_w  = WAY_W'(w); end
      if (open_way[w])  begin any_open = 1'b1; open_w = WAY_W'(w); end
    end
  end

  assign hit_addr   = cand_addr[hit_w];
  assign hit_ent    = EIDX_W'(int'(set_sel) * WAYS + int'(hit_w));
  assign open_ent   = EIDX_W'(int'(set_sel) * WAYS + int'(open_w));
  assign ev_dup     = (ph_q == PH_LOOKUP) && any_hit;
  assign ev_nospace = (ph_q == PH_LOOKUP) && !any_hit && !any_free;
  assign ev_alloc   = (ph_q == PH_LOOKUP) && !any_hit && any_free;
  assign ev_ins     = ev_alloc && any_open;

  dedup_hashtab #(
    .SET_W(SET_W), .WAYS(WAYS), .CNT_W(CNT_W), .SADDR_W(SADDR_W)
  ) u_tab (
    .clk(clk), .rst_n(rst_n),
    .lk_set(set_sel), .lk_hash(q_hash),
    .cand(cand), .cand_addr(cand_addr), .open_way(open_way),
    .dec_en(ev_dec), .dec_idx(inv_ptr_q[rel_loc]), .dec_last(dec_last),
    .inc_en(ev_dup), .inc_idx(hit_ent),
    .ins_en(ev_ins), .ins_idx(open_ent), .ins_hash(q_hash), .ins_addr(pick_idx)
  );

  dedup_freemap #(.SADDR_W(SADDR_W)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pref_idx(q_addr[SADDR_W-1:0]), .pref_ok(in_store(q_addr)),
    .alloc_en(ev_alloc), .alloc_idx(pick_idx),
    .rel_en(ev_free), .rel_idx(rel_loc),
    .any_free(any_free), .pick_idx(pick_idx), .pick_pref(pick_pref),
    .free_cnt(free_count)
  );

  assign busy = (ph_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      q_addr <= '0;
      q_data <= '0;
      q_hash <= '0;
      done   <= 1'b0;
      status <= WS_STORED;
      for (int i = 0; i < NS; i++) begin
        store_q[i]   <= '0;
        inv_val_q[i] <= 1'b0;
        inv_ptr_q[i] <= '0;
      end
      for (int i = 0; i < NL; i++) begin
        fwd_val_q[i] <= 1'b0;
        fwd_id_q[i]  <= 1'b0;
        fwd_ptr_q[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (wr_req) begin
          q_addr <= wr_addr;
          q_data <= wr_data;
          q_hash <= crc8_of(wr_data);
          ph_q   <= PH_RELEASE;
        end
        PH_RELEASE: begin
          if (rel_has) fwd_val_q[q_addr] <= 1'b0;
          if (ev_free) inv_val_q[rel_loc] <= 1'b0;
          ph_q <= PH_LOOKUP;
        end
        PH_LOOKUP: begin
          done <= 1'b1;
          ph_q <= PH_IDLE;
          if (any_hit) begin
            status            <= WS_DUP;
            fwd_val_q[q_addr] <= 1'b1;
            fwd_id_q[q_addr]  <= in_store(q_addr) && (hit_addr == q_addr[SADDR_W-1:0]);
            fwd_ptr_q[q_addr] <= hit_addr;
          end else if (!any_free) begin
            status <= WS_NOSPACE;
          end else begin
            status            <= any_open ? WS_STORED : WS_UNINDEXED;
            store_q[pick_idx] <= q_data;
            fwd_val_q[q_addr] <= 1'b1;
            fwd_id_q[q_addr]  <= pick_pref;
            if (!pick_pref) fwd_ptr_q[q_addr] <= pick_idx;
            inv_val_q[pick_idx] <= any_open;
            inv_ptr_q[pick_idx] <= open_ent;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // read port
  logic [SADDR_W-1:0] rd_at;
  assign rd_at = fwd_id_q[rd_addr] ? rd_addr[SADDR_W-1:0] : fwd_ptr_q[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_loc   <= '0;
      rd_ident <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        if (fwd_val_q[rd_addr]) begin
          rd_data  <= store_q[rd_at];
          rd_loc   <= rd_at;
          rd_ident <= fwd_id_q[rd_addr];
        end else begin
          rd_data  <= '0;
          rd_loc   <= '0;
          rd_ident <= 1'b0;
        end
      end
    end
  end

  // R3
  dup_keeps_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dup |=> (free_count == $past(free_count)));
  // R8
  nospace_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nospace |-> (free_count == '0));
  // R4
  release_gains_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_free |=> (free_count == $past(free_count) + 1'b1));
  // R11
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

endmodule

// File: tb/tb_dedup_remap.sv
module tb_dedup_remap;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4;
  localparam int SW = 2;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0;
  logic [LW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic busy, done, rd_valid, rd_ident;
  logic [1:0] status;
  logic rd_req = 1'b0;
  logic [LW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] rd_loc;
  logic [SW:0] free_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  dedup_remap #(.LADDR_W(LW), .SADDR_W(SW), .DATA_W(DW), .SET_W(1), .WAYS(2), .CNT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .status(status), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_loc(rd_loc), .rd_ident(rd_ident),
    .free_count(free_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // byte-at-a-time CRC-8, poly 0x07 (R2)
  function automatic logic [7:0] ref_crc(input logic [31:0] d);
    logic [7:0] c = 8'h00;
    for (int k = 3; k >= 0; k--) begin
      c = c ^ d[8*k +: 8];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  logic [1:0] got_st;
  logic [SW:0] got_free;

  task automatic do_write(input logic [LW-1:0] a, input logic [DW-1:0] d);
    int waited = 0;
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    while (!done && waited < 50) begin @(negedge clk); waited++; end
    if (!done) begin n_fail++; n_chk++; $display("FAIL R11 actual=no_done expected=done"); end
    got_st = status; got_free = free_count;
  endtask

  task automatic do_read(input logic [LW-1:0] a);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  typedef struct packed {
    logic          is_wr;
    logic [LW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    st;
    logic [SW:0]   free;
    logic [SW-1:0] loc;
    logic          ident;
  } vec_t;

  localparam logic [DW-1:0] VA = 32'hA5A5_0001;
  localparam logic [DW-1:0] VB = 32'h0BAD_F00D;

  // counts saturate at 3 in this bench (CNT_W=2), 4 storage slots
  localparam vec_t VEC [14] = '{
    '{1'b1, 4'd0, VA, 2'd0, 3'd3, 2'd0, 1'b0},  // R6 identity placement
    '{1'b0, 4'd0, VA, 2'd0, 3'd3, 2'd0, 1'b1},  // R6 R9
    '{1'b1, 4'd5, VA, 2'd1, 3'd3, 2'd0, 1'b0},  // R3 dup
    '{1'b0, 4'd5, VA, 2'd0, 3'd3, 2'd0, 1'b0},  // R3
    '{1'b1, 4'd9, VB, 2'd0, 3'd2, 2'd0, 1'b0},  // R6 lowest free
    '{1'b0, 4'd9, VB, 2'd0, 3'd2, 2'd1, 1'b0},  // R6
    '{1'b1, 4'd0, VB, 2'd1, 3'd2, 2'd0, 1'b0},  // R4 dec no free
    '{1'b0, 4'd0, VB, 2'd0, 3'd2, 2'd1, 1'b0},  // R4
    '{1'b1, 4'd5, VB, 2'd1, 3'd3, 2'd0, 1'b0},  // R4 last ref frees
    '{1'b0, 4'd5, VB, 2'd0, 3'd3, 2'd1, 1'b0},  // R3
    '{1'b1, 4'd2, VB, 2'd0, 3'd2, 2'd0, 1'b0},  // R5 saturated fallback
    '{1'b0, 4'd2, VB, 2'd0, 3'd2, 2'd2, 1'b1},  // R5
    '{1'b1, 4'd3, VB, 2'd1, 3'd2, 2'd0, 1'b0},  // R5 new entry matches
    '{1'b0, 4'd3, VB, 2'd0, 3'd2, 2'd2, 1'b0}   // R5
  };

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] xs [3];
    int nx;
    int pulses;

    do_reset();
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 free", free_count, 4);
    do_read(4'd0);
    chk("R1 rd_data", rd_data, 0);
    chk("R9 rd_valid", rd_valid, 1);

    foreach (VEC[i]) begin
      if (VEC[i].is_wr) begin
        do_write(VEC[i].addr, VEC[i].data);
        chk($sformatf("R11 status v%0d", i), got_st, VEC[i].st);
        chk($sformatf("R4 free v%0d", i), got_free, VEC[i].free);
      end else begin
        do_read(VEC[i].addr);
        chk($sformatf("R9 data v%0d", i), rd_data, VEC[i].data);
        chk($sformatf("R6 loc v%0d", i), rd_loc, VEC[i].loc);
        chk($sformatf("R6 ident v%0d", i), rd_ident, VEC[i].ident);
      end
    end

    // three distinct blocks landing in set 0 (R2)
    nx = 0;
    for (int k = 0; k < 4096 && nx < 3; k++) begin
      if (ref_crc(32'h3000_0000 + k) [0] == 1'b0) begin
        xs[nx] = 32'h3000_0000 + k;
        nx++;
      end
    end

    do_reset();
    do_write(4'd0, xs[0]);
    chk("R2 st x0", got_st, 0);
    do_write(4'd1, xs[1]);
    chk("R2 st x1", got_st, 0);
    do_write(4'd2, xs[2]);
    chk("R7 set full", got_st, 2);
    chk("R7 free", got_free, 1);
    do_write(4'd6, xs[2]);
    chk("R7 never matched", got_st, 2);
    chk("R7 free0", got_free, 0);
    do_write(4'd7, 32'h7777_7777);
    chk("R8 nospace", got_st, 3);
    chk("R8 free", got_free, 0);
    do_read(4'd7);
    chk("R8 unmapped", rd_data, 0);
    do_write(4'd6, xs[0]);
    chk("R4 unindexed freed dup", got_st, 1);
    chk("R4 free", got_free, 1);
    do_read(4'd6);
    chk("R3 data", rd_data, xs[0]);
    chk("R3 loc", rd_loc, 0);
    do_read(4'd2);
    chk("R7 data kept", rd_data, xs[2]);

    // write accepted, second request during busy ignored
    pulses = 0;
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 4'd10; wr_data = 32'h5555_0000;
    @(negedge clk);
    chk("R10 busy", busy, 1);
    wr_addr = 4'd11; wr_data = 32'h6666_0000;
    @(negedge clk);
    wr_req = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (done) pulses++;
      @(negedge clk);
    end
    chk("R11 one pulse", pulses, 1);
    do_read(4'd11);
    chk("R10 ignored", rd_data, 0);
    do_read(4'd10);
    chk("R10 first write", rd_data, 32'h5555_0000);

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule